// File: doc/BRIEF.md
# Address Sequence Command Detector

This block listens to the control strobes and address of an asynchronous byte-wide memory port after they have been brought into a system clock domain. It counts read cycles that walk through a fixed chain of addresses. The chain has five common prefix addresses followed by one selector address. When the sixth read completes the chain, the block raises exactly one of four single-cycle command strobes: nonvolatile store, nonvolatile recall, automatic-store off, or automatic-store on.

A write cycle, or a read of any address that is not next in the chain, abandons the partial chain. A controller that carries out store and recall operations drives a busy input. While that input is high, the detector stays idle and takes no notice of the strobes. The current chain position is visible on a small step output. A consumer can therefore observe progress, and a bench can see aborts directly.

Top module: `seqdet_top`

## Requirements
- R1: After reset, reads of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, move `step` through 1, 2, 3, 4 and 5.
- R2: At step 5, a read of 0x8FC0 pulses `cmd_store` high for one clock and returns `step` to 0.
- R3: At step 5, a read of 0x4C63 pulses `cmd_recall` high for one clock and returns `step` to 0.
- R4: At step 5, a read of 0x8B45 pulses `cmd_as_off` high for one clock and returns `step` to 0.
- R5: At step 5, a read of 0x4B46 pulses `cmd_as_on` high for one clock and returns `step` to 0.
- R6: Address bit 16 takes no part in matching. A chain read with bit 16 set behaves the same as one with bit 16 clear.
- R7: A write cycle returns `step` to 0 and produces no command. A write cycle is `ce_n` and `we_n` both low, seen as the start of that overlap.
- R8: A read of an address that is not next in the chain produces no command. If the offending address is 0x4E38, `step` becomes 1; otherwise `step` becomes 0.
- R9: A falling `ce_n` with `we_n` high counts as a read whatever the level of `oe_n`. A falling `oe_n` while `ce_n` is low and `we_n` is high also counts as a read.
- R10: While `busy` is high, `step` is held at 0, no command fires, and reads that fall inside that window do not advance the chain.
- R11: During and right after reset, `step` is 0 and all four command outputs are low.
- R12: At most one command output is high in any cycle, and no command stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | 17 | Byte address; only the low 16 bits are compared |
| busy | input | 1 | High while a store or recall is being executed |
| cmd_store | output | 1 | One-cycle store command |
| cmd_recall | output | 1 | One-cycle recall command |
| cmd_as_off | output | 1 | One-cycle automatic-store disable command |
| cmd_as_on | output | 1 | One-cycle automatic-store enable command |
| step | output | 3 | Number of chain reads matched so far (0 to 5) |

## Verification
The assertions assume the address is steady for at least three clocks around each qualifying strobe edge, because it is captured without synchronisation. They also assume each strobe level lasts longer than the two-flop synchroniser, so that no edge is lost. The stimulus sets the address one clock before every strobe falls. It holds every strobe level for four clocks. It changes `busy` only when all strobes are idle, so no event can be left in the pipeline when busy is released.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    parameter int ADDR_W  = 17;
    parameter int CMP_W   = 16;
    parameter int PREFIX_N = 5;
    parameter int STEP_W  = $clog2(PREFIX_N + 1);

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_STORE,
        CMD_RECALL,
        CMD_AS_OFF,
        CMD_AS_ON
    } cmd_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_READ,
        EV_WRITE
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e           kind;
        logic [CMP_W-1:0]   addr;
    } bus_ev_t;

    // Common part of every chain, indexed by the number of reads already matched.
    function automatic logic [CMP_W-1:0] prefix_addr(input int idx);
        case (idx)
            0:       return 16'h4E38;
            1:       return 16'hB1C7;
            2:       return 16'h83E0;
            3:       return 16'h7C1F;
            default: return 16'h703F;
        endcase
    endfunction

    // Selector read: picks the action, or none.
    function automatic cmd_e decode_final(input logic [CMP_W-1:0] a);
        case (a)
            16'h8FC0: return CMD_STORE;
            16'h4C63: return CMD_RECALL;
            16'h8B45: return CMD_AS_OFF;
            16'h4B46: return CMD_AS_ON;
            default:  return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/seqdet_sync.sv
module seqdet_sync #(
    parameter int WIDTH     = 3,
    parameter int STAGES    = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= {WIDTH{RST_VAL}};
                else if (i == 0) chain[i] <= d;
                else chain[i] <= chain[(i == 0) ? 0 : i - 1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/seqdet_strobe.sv
module seqdet_strobe
    import seqdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              ce_s,
    input  logic              oe_s,
    input  logic              we_s,
    input  logic [ADDR_W-1:0] addr,
    output bus_ev_t           ev
);
    logic ce_d, oe_d, wr_d;
    logic wr_act, ce_fall, oe_fall, rd_hit, wr_hit;
    logic unused_hi_bits;

    assign wr_act  = ~ce_s & ~we_s;
    assign ce_fall = ce_d & ~ce_s;
    assign oe_fall = oe_d & ~oe_s;
    assign rd_hit  = we_s & (ce_fall | (oe_fall & ~ce_s));
    assign wr_hit  = wr_act & ~wr_d;
    assign unused_hi_bits = ^addr[ADDR_W-1:CMP_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_d <= 1'b1;
            oe_d <= 1'b1;
            wr_d <= 1'b0;
            ev   <= '{kind: EV_NONE, addr: '0};
        end else begin
            ce_d <= ce_s;
            oe_d <= oe_s;
            wr_d <= wr_act;
            ev.addr <= addr[CMP_W-1:0];
            if (busy)        ev.kind <= EV_NONE;
            else if (wr_hit) ev.kind <= EV_WRITE;
            else if (rd_hit) ev.kind <= EV_READ;
            else             ev.kind <= EV_NONE;
        end
    end

    assert_busy_masks_events_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> ev.kind == EV_NONE);
endmodule

// File: rtl/seqdet_chain.sv
module seqdet_chain
    import seqdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  bus_ev_t           ev,
    output logic [STEP_W-1:0] step,
    output cmd_e              cmd
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX_N);

    logic [STEP_W-1:0] step_nxt;
    cmd_e              cmd_nxt;
    logic              restart;

    assign restart = (ev.addr == prefix_addr(0));

    always_comb begin
        step_nxt = step;
        cmd_nxt  = CMD_NONE;
        case (ev.kind)
            EV_WRITE: step_nxt = '0;
            EV_READ: begin
                if (step == LAST) begin
                    cmd_nxt  = decode_final(ev.addr);
                    step_nxt = (cmd_nxt == CMD_NONE && restart) ? STEP_W'(1) : '0;
                end else if (ev.addr == prefix_addr(int'(step))) begin
                    step_nxt = step + 1'b1;
                end else begin
                    step_nxt = restart ? STEP_W'(1) : '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || busy) begin
            step <= '0;
            cmd  <= CMD_NONE;
        end else begin
            step <= step_nxt;
            cmd  <= cmd_nxt;
        end
    end

    assert_step_range_R1: assert property (@(posedge clk) disable iff (rst)
        step <= LAST);
    assert_cmd_after_full_prefix_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NONE) |-> $past(step) == LAST);
    assert_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (ev.kind == EV_WRITE && !busy) |=> (step == '0 && cmd == CMD_NONE));
    assert_busy_idles_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> (step == '0 && cmd == CMD_NONE));
endmodule

// File: rtl/seqdet_top.sv
module seqdet_top
    import seqdet_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [16:0]       addr,
    input  logic              busy,
    output logic              cmd_store,
    output logic              cmd_recall,
    output logic              cmd_as_off,
    output logic              cmd_as_on,
    output logic [2:0]        step
);
    logic [2:0]        ctl_s;
    bus_ev_t           ev;
    cmd_e              cmd;
    logic [STEP_W-1:0] step_i;

    seqdet_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ce_n, oe_n, we_n}),
        .q   (ctl_s)
    );

    seqdet_strobe u_strobe (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .ce_s (ctl_s[2]),
        .oe_s (ctl_s[1]),
        .we_s (ctl_s[0]),
        .addr (addr),
        .ev   (ev)
    );

    seqdet_chain u_chain (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .ev   (ev),
        .step (step_i),
        .cmd  (cmd)
    );

    assign step       = 3'(step_i);
    assign cmd_store  = (cmd == CMD_STORE);
    assign cmd_recall = (cmd == CMD_RECALL);
    assign cmd_as_off = (cmd == CMD_AS_OFF);
    assign cmd_as_on  = (cmd == CMD_AS_ON);

    assert_single_cmd_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_store, cmd_recall, cmd_as_off, cmd_as_on}));
    assert_cmd_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        (cmd_store | cmd_recall | cmd_as_off | cmd_as_on) |=>
        !(cmd_store | cmd_recall | cmd_as_off | cmd_as_on));
endmodule

// File: tb/sim_seqdet_top.sv
`timescale 1ns/1ps
module sim_seqdet_top;
    logic        clk = 1'b0;
    logic        rst, ce_n, oe_n, we_n, busy;
    logic [16:0] addr;
    logic        cmd_store, cmd_recall, cmd_as_off, cmd_as_on;
    logic [2:0]  step;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    localparam logic [15:0] PFX [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
    localparam logic [3:0] K_STORE = 4'b1000, K_RECALL = 4'b0100,
                           K_OFF = 4'b0010, K_ON = 4'b0001;

    always #2.5 clk = ~clk;

    seqdet_top u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .busy(busy), .cmd_store(cmd_store), .cmd_recall(cmd_recall),
        .cmd_as_off(cmd_as_off), .cmd_as_on(cmd_as_on), .step(step)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] got();
        return {cmd_store, cmd_recall, cmd_as_off, cmd_as_on};
    endfunction

    // Monitor: every command pulse must match the oldest expected item.
    always @(negedge clk) begin
        logic [3:0] e;
        string      t;
        if (!rst && got() != 4'b0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 command without valid chain", got(), 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(got() == e, t, got(), e);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_cmd(input logic [3:0] k, input string tag);
        exp_q.push_back(k);
        tag_q.push_back(tag);
    endtask

    task automatic rd_ce(input logic [16:0] a);
        @(negedge clk) addr = a;
        @(negedge clk) ce_n = 1'b0;
        idle(4);
        ce_n = 1'b1;
        idle(4);
    endtask

    task automatic rd_oe(input logic [16:0] a);
        @(negedge clk) addr = a;
        @(negedge clk) oe_n = 1'b0;
        idle(4);
        oe_n = 1'b1;
        idle(4);
    endtask

    task automatic wr(input logic [16:0] a);
        @(negedge clk) addr = a;
        we_n = 1'b0;
        idle(1);
        ce_n = 1'b0;
        idle(4);
        ce_n = 1'b1;
        idle(1);
        we_n = 1'b1;
        idle(4);
    endtask

    task automatic prefix(input int n, input bit hi);
        for (int i = 0; i < n; i++) rd_ce({hi, PFX[i]});
    endtask

    task automatic step_chk(input int e, input string tag);
        check(step == 3'(e), tag, step, e);
    endtask

    initial begin
        #(200000 * 5.0);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; busy = 1'b0; addr = '0;
        idle(4);
        check(step == 3'd0 && got() == 4'b0, "R11 during reset", {step, got()}, 0);
        rst = 1'b0;
        idle(3);
        check(step == 3'd0 && got() == 4'b0, "R11 after reset", {step, got()}, 0);

        // R1: prefix walk, R9: reads via ce falling with oe high
        for (int i = 0; i < 5; i++) begin
            rd_ce({1'b0, PFX[i]});
            step_chk(i + 1, "R1 step advance");
        end
        expect_cmd(K_STORE, "R2 store select");
        rd_ce(17'h08FC0);
        step_chk(0, "R2 step back to idle");

        prefix(5, 1'b0);
        expect_cmd(K_RECALL, "R3 recall select");
        rd_ce(17'h04C63);
        step_chk(0, "R3 step back to idle");

        prefix(5, 1'b0);
        expect_cmd(K_OFF, "R4 autostore off select");
        rd_ce(17'h08B45);
        step_chk(0, "R4 step back to idle");

        prefix(5, 1'b0);
        expect_cmd(K_ON, "R5 autostore on select");
        rd_ce(17'h04B46);
        step_chk(0, "R5 step back to idle");

        // R6: bit 16 set everywhere
        prefix(5, 1'b1);
        step_chk(5, "R6 prefix with bit16 set");
        expect_cmd(K_STORE, "R6 store with bit16 set");
        rd_ce(17'h18FC0);

        // R9: first read via ce, remaining via oe with ce held low
        @(negedge clk) addr = {1'b0, PFX[0]};
        @(negedge clk) ce_n = 1'b0;
        idle(8);
        step_chk(1, "R9 ce read with oe high");
        for (int i = 1; i < 5; i++) begin
            rd_oe({1'b0, PFX[i]});
            step_chk(i + 1, "R9 oe-strobed read");
        end
        expect_cmd(K_RECALL, "R9 recall via oe strobes");
        rd_oe(17'h04C63);
        ce_n = 1'b1;
        idle(4);
        step_chk(0, "R9 idle after oe chain");

        // R7: write aborts mid-chain, chain does not resume
        prefix(3, 1'b0);
        step_chk(3, "R7 setup");
        wr({1'b0, PFX[3]});
        step_chk(0, "R7 write aborts");
        rd_ce({1'b0, PFX[3]});
        step_chk(0, "R7 no resume after write");

        // R8: wrong address aborts; chain-start address restarts
        prefix(4, 1'b0);
        rd_ce(17'h01234);
        step_chk(0, "R8 wrong address to idle");
        prefix(2, 1'b0);
        rd_ce({1'b0, PFX[0]});
        step_chk(1, "R8 restart on first address");
        for (int i = 1; i < 5; i++) rd_ce({1'b0, PFX[i]});
        step_chk(5, "R8 chain after restart");
        rd_ce(17'h00000);
        step_chk(0, "R8 bad selector no command");
        prefix(5, 1'b0);
        rd_ce({1'b0, PFX[0]});
        step_chk(1, "R8 restart at selector slot");
        for (int i = 1; i < 5; i++) rd_ce({1'b0, PFX[i]});
        expect_cmd(K_OFF, "R8 command after restart");
        rd_ce(17'h08B45);

        // R10: busy clears and masks
        prefix(3, 1'b0);
        step_chk(3, "R10 setup");
        @(negedge clk) busy = 1'b1;
        idle(2);
        step_chk(0, "R10 busy clears step");
        rd_ce({1'b0, PFX[0]});
        step_chk(0, "R10 read ignored while busy");
        @(negedge clk) busy = 1'b0;
        idle(4);
        step_chk(0, "R10 still idle after busy");
        prefix(5, 1'b0);
        expect_cmd(K_ON, "R10 works after busy");
        rd_ce(17'h04B46);

        idle(10);
        check(exp_q.size() == 0, "R2 expected commands all seen", exp_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule